// File: doc/BRIEF.md
# USB Host Controller Operational Register File

This block holds the operational registers of a USB host controller that follows the open host controller register model and serves two root-hub ports. Software reaches it over a simple 32-bit bus with word addressing: a write is taken on the clock edge where `wr_en_i` is high, and a read is combinational from `addr_i` to `rdata_o`. The block only stores register state and applies the defined reset values. It does no list processing, frame timing or USB signalling.

There are two kinds of reset. The active-low asynchronous input `rst_ni` is the cold, hardware reset. It clears the control register completely and puts the functional state in Reset. Software asks for the second kind by writing 1 to bit 0 of the command/status word. That reset keeps only the interrupt-routing and remote-wakeup-connected bits of the control register and puts the functional state in Suspend. Both kinds load the same defaults into every other register. The current functional state is also driven on a dedicated output, so that neighbouring logic can follow it.

Top module: `usbhc_regfile`

## Requirements
- R1: After a cold reset the control word (offset 1) reads 0, and `func_state_o` is 2'b00 (Reset).
- R2: Writing a word with bit 0 set to offset 2 starts a software reset on that clock edge. Afterwards the control word keeps bits 9:8, bits 7:6 read 2'b11 (Suspend) and every other bit reads 0. Offset 2 always reads 0.
- R3: Bits 10:0 of the control word are writable and bits 31:11 read 0. `func_state_o` follows control bits 7:6, with 00 = Reset, 01 = Resume, 10 = Operational and 11 = Suspend.
- R4: After either kind of reset the interrupt enable (offset 4) reads 32'h8000_0000 and the interrupt status (offset 3) reads 0.
- R5: Writing offset 4 sets the enable bits where the data has a 1. Writing offset 5 clears the enable bits where the data has a 1. Only bits 31 and 6:0 exist. Offset 5 reads back the enable value.
- R6: The writable pointers are HCCA at offset 6 (bits 31:8) and the control-list head at offset 8 and the bulk-list head at offset 10 (bits 31:4 each). The other bits read 0. All three reset to 0 under both kinds of reset.
- R7: The frame interval (offset 13) resets to 32'h2778_2EDF under both kinds of reset. Bits 31, 29:16 and 13:0 are writable.
- R8: Offset 0 reads 32'h10. Offset 18 reads 32'h202, which is the no-power-switching bit 9 together with a port count of 2. Offsets 7, 9, 11, 12, 14, 15, 16, 19, 21 and 22 read 0.
- R9: Offsets 17, 20 and 23 and above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | ADDR_W (8) | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| func_state_o | output | 2 | Current host-controller functional state |

## Verification
The assertions assume that each cycle carries at most one access, and that `wr_en_i`, `addr_i` and `wdata_i` are stable around the rising edge. They also assume that a software-reset write and an ordinary write never fall on the same edge. The bench drives every input on the falling edge and issues one access per task call. The address goes past the mapped range and the data is fully random, so the bench also exercises the unmapped offsets and the bits that do not exist.

// File: rtl/usbhc_pkg.sv
package usbhc_pkg;

  typedef enum logic [1:0] {
    FS_RESET   = 2'b00,
    FS_RESUME  = 2'b01,
    FS_OPER    = 2'b10,
    FS_SUSPEND = 2'b11
  } func_state_e;

  localparam int OFF_REV    = 0;
  localparam int OFF_CTRL   = 1;
  localparam int OFF_CMD    = 2;
  localparam int OFF_ISTS   = 3;
  localparam int OFF_IEN    = 4;
  localparam int OFF_IDIS   = 5;
  localparam int OFF_HCCA   = 6;
  localparam int OFF_CHEAD  = 8;
  localparam int OFF_BHEAD  = 10;
  localparam int OFF_FMI    = 13;
  localparam int OFF_RHA    = 18;

  localparam logic [31:0] REV_VAL   = 32'h0000_0010;
  localparam logic [31:0] CTRL_MASK = 32'h0000_07FF;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_0300;   // routing + wakeup-connected
  localparam logic [31:0] IEN_MASK  = 32'h8000_007F;
  localparam logic [31:0] IEN_MIE   = 32'h8000_0000;
  localparam logic [31:0] RHA_NOPWR = 32'h0000_0200;

  localparam int NUM_RW = 4;
  localparam int          RW_OFF  [NUM_RW] = '{OFF_HCCA, OFF_CHEAD, OFF_BHEAD, OFF_FMI};
  localparam logic [31:0] RW_MASK [NUM_RW] = '{32'hFFFF_FF00, 32'hFFFF_FFF0,
                                               32'hFFFF_FFF0, 32'hBFFF_3FFF};

endpackage

// File: rtl/usbhc_ctrl_reg.sv
module usbhc_ctrl_reg
  import usbhc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sw_rst_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] ctrl_o
);

  logic [10:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= {3'b000, FS_RESET, 6'b0};
    end else if (sw_rst_i) begin
      ctrl_q      <= ctrl_q & CTRL_KEEP[10:0];
      ctrl_q[7:6] <= FS_SUSPEND;
    end else if (wr_i) begin
      ctrl_q <= wdata_i[10:0];
    end
  end

  assign ctrl_o = {21'b0, ctrl_q};

  // R2
  sw_rst_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (ctrl_o == (($past(ctrl_o) & CTRL_KEEP) | 32'h0000_00C0)));

  // R3
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sw_rst_i) |=> (ctrl_o == ($past(wdata_i) & CTRL_MASK)));

endmodule

// File: rtl/usbhc_intr_regs.sv
module usbhc_intr_regs
  import usbhc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sw_rst_i,
  input  logic        set_i,
  input  logic        clr_i,
  input  logic        ack_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] en_o,
  output logic [31:0] sts_o
);

  logic [31:0] en_q, sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= IEN_MIE;
      sts_q <= '0;
    end else if (sw_rst_i) begin
      en_q  <= IEN_MIE;
      sts_q <= '0;
    end else begin
      if (set_i) en_q  <= en_q | (wdata_i & IEN_MASK);
      if (clr_i) en_q  <= en_q & ~(wdata_i & IEN_MASK);
      if (ack_i) sts_q <= sts_q & ~wdata_i;   // write 1 to clear
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;

  // R4
  intr_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (en_o == IEN_MIE && sts_o == '0));

  // R5
  intr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !sw_rst_i) |=> (en_o == ($past(en_o) | ($past(wdata_i) & IEN_MASK))));

  // R5
  intr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !sw_rst_i) |=> (en_o == ($past(en_o) & ~($past(wdata_i) & IEN_MASK))));

endmodule

// File: rtl/usbhc_rw_word.sv
module usbhc_rw_word #(
  parameter logic [31:0] MASK = 32'hFFFF_FFFF,
  parameter logic [31:0] RST  = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sw_rst_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);

  logic [31:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= RST & MASK;
    else if (sw_rst_i) q <= RST & MASK;
    else if (wr_i)     q <= wdata_i & MASK;
  end

  assign q_o = q;

  // R6 R7
  word_sw_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (q_o == RST));

  // R6 R7
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !sw_rst_i) |=> $stable(q_o));

endmodule

// File: rtl/usbhc_regfile.sv
module usbhc_regfile
  import usbhc_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          NUM_PORTS  = 2,
  parameter logic [13:0] FRAME_BITS = 14'h2EDF,
  parameter logic [13:0] FS_MAX_PKT = 14'h2778
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [1:0]        func_state_o
);

  localparam logic [31:0] FMI_RST = {2'b00, FS_MAX_PKT, 2'b00, FRAME_BITS};
  localparam logic [31:0] RHA_VAL = RHA_NOPWR | 32'(NUM_PORTS);

  logic [31:0] a_w;
  logic        sw_rst;
  logic [31:0] ctrl, ien, ists;
  logic [31:0] rw_q [NUM_RW];

  assign a_w    = 32'(addr_i);
  assign sw_rst = wr_en_i && (a_w == OFF_CMD) && wdata_i[0];

  usbhc_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_rst_i (sw_rst),
    .wr_i     (wr_en_i && a_w == OFF_CTRL),
    .wdata_i  (wdata_i),
    .ctrl_o   (ctrl)
  );

  usbhc_intr_regs u_intr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_rst_i (sw_rst),
    .set_i    (wr_en_i && a_w == OFF_IEN),
    .clr_i    (wr_en_i && a_w == OFF_IDIS),
    .ack_i    (wr_en_i && a_w == OFF_ISTS),
    .wdata_i  (wdata_i),
    .en_o     (ien),
    .sts_o    (ists)
  );

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    localparam logic [31:0] RST_V = (RW_OFF[g] == OFF_FMI) ? FMI_RST : 32'h0;
    usbhc_rw_word #(.MASK(RW_MASK[g]), .RST(RST_V)) u_word (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sw_rst_i (sw_rst),
      .wr_i     (wr_en_i && a_w == RW_OFF[g]),
      .wdata_i  (wdata_i),
      .q_o      (rw_q[g])
    );
  end

  // Current pointers, done head, frame counters, port status: held at reset value 0.
  always_comb begin
    rdata_o = '0;
    unique case (a_w)
      OFF_REV:  rdata_o = REV_VAL;
      OFF_CTRL: rdata_o = ctrl;
      OFF_ISTS: rdata_o = ists;
      OFF_IEN,
      OFF_IDIS: rdata_o = ien;
      OFF_RHA:  rdata_o = RHA_VAL;
      default: begin
        for (int i = 0; i < NUM_RW; i++)
          if (a_w == RW_OFF[i]) rdata_o = rw_q[i];
      end
    endcase
  end

  assign func_state_o = ctrl[7:6];

  // R1
  cold_state_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (func_state_o == FS_RESET));

  // R2
  sw_rst_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst |=> (func_state_o == FS_SUSPEND));

endmodule

// File: tb/usbhc_regfile_bench.sv
module usbhc_regfile_bench;

  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  func_state_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_ctrl, m_ien, m_hcca, m_chead, m_bhead, m_fmi;

  always #(CLK_P/2) clk_i = ~clk_i;

  usbhc_regfile u_usbhc_regfile (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .func_state_o(func_state_o)
  );

  function automatic void model_defaults();
    m_ien = 32'h8000_0000; m_hcca = 0; m_chead = 0; m_bhead = 0;
    m_fmi = 32'h2778_2EDF;
  endfunction

  function automatic void model_cold();
    m_ctrl = 0;
    model_defaults();
  endfunction

  function automatic void model_write(int a, logic [31:0] d);
    case (a)
      1:  m_ctrl  = d & 32'h7FF;
      2:  if (d[0]) begin m_ctrl = (m_ctrl & 32'h300) | 32'hC0; model_defaults(); end
      4:  m_ien   = m_ien | (d & 32'h8000_007F);
      5:  m_ien   = m_ien & ~(d & 32'h8000_007F);
      6:  m_hcca  = d & 32'hFFFF_FF00;
      8:  m_chead = d & 32'hFFFF_FFF0;
      10: m_bhead = d & 32'hFFFF_FFF0;
      13: m_fmi   = d & 32'hBFFF_3FFF;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    case (a)
      0:  return 32'h10;
      1:  return m_ctrl;
      4, 5: return m_ien;
      6:  return m_hcca;
      8:  return m_chead;
      10: return m_bhead;
      13: return m_fmi;
      18: return 32'h202;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int a);
    case (a)
      1:  return "R3";
      2:  return "R2";
      3, 4: return "R4";
      5:  return "R5";
      6, 8, 10: return "R6";
      13: return "R7";
      17, 20: return "R9";
      default: return (a > 22) ? "R9" : "R8";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 8'(a); wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(int a);
    addr_i = 8'(a);
    #1;
    chk(req_of(a), rdata_o, exp_rd(a));
  endtask

  task automatic rd_tag(string req, int a);
    addr_i = 8'(a);
    #1;
    chk(req, rdata_o, exp_rd(a));
  endtask

  task automatic fs_chk(string req, logic [1:0] exp);
    #1;
    chk(req, 32'(func_state_o), 32'(exp));
  endtask

  task automatic cold_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_cold();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_cold();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R4 R6 R7 R8 R9: cold defaults over the whole map
    rd_tag("R1", 1);
    fs_chk("R1", 2'b00);
    for (int a = 0; a < 40; a++) rd(a);

    // R3: writable control bits and state encoding
    wr(1, 32'hFFFF_FFFF); rd_tag("R3", 1); fs_chk("R3", 2'b11);
    wr(1, 32'h0000_0080); fs_chk("R3", 2'b10);
    wr(1, 32'h0000_0040); fs_chk("R3", 2'b01);

    // R2: software reset keeps bits 9:8
    wr(1, 32'h0000_03BF);
    wr(6, 32'hDEAD_BEEF); wr(13, 32'h1234_5678); wr(5, 32'h8000_0000);
    wr(2, 32'h0000_0001);
    rd_tag("R2", 1); fs_chk("R2", 2'b11); rd_tag("R2", 2);
    rd_tag("R4", 4); rd_tag("R6", 6); rd_tag("R7", 13);

    // R2: bit 0 clear -> no reset
    wr(1, 32'h0000_0085);
    wr(2, 32'hFFFF_FFFE); rd_tag("R2", 1);

    // R1: cold reset clears wakeup-connected
    wr(1, 32'h0000_0300);
    cold_reset();
    rd_tag("R1", 1); fs_chk("R1", 2'b00); rd_tag("R4", 4);

    // R5: set then clear enable
    wr(4, 32'h0000_00FF); rd_tag("R5", 4);
    wr(5, 32'h8000_0005); rd_tag("R5", 5);

    // R9: unmapped writes have no effect anywhere
    wr(17, 32'hFFFF_FFFF); wr(20, 32'hFFFF_FFFF); wr(30, 32'hFFFF_FFFF);
    for (int a = 0; a < 32; a++) rd_tag("R9", a);

    // Random traffic
    for (int i = 0; i < 600; i++) begin
      int a;
      logic [31:0] d;
      a = $urandom_range(0, 35);
      d = $urandom();
      if (a == 2 && $urandom_range(0, 3) != 0) d[0] = 1'b0;
      wr(a, d);
      rd(a);
      rd($urandom_range(0, 35));
      fs_chk("R3", m_ctrl[7:6]);
      if ($urandom_range(0, 99) == 0) begin
        cold_reset();
        rd_tag("R1", 1);
      end
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule